// File: doc/BRIEF.md
# Configuration Store with Readback Lock and Signature Word

This block stores the configuration of a programmable logic array: a set of fuse rows, a 64-bit user signature word and a security bit. A programmer interface sends one command per cycle over a valid/ready handshake. The commands write a row, write the signature, set the security bit, erase the whole store, read a row and read the signature. Reads answer one cycle after they are accepted.

Writing a row replaces the whole row, so no separate erase is needed before reprogramming. Once the security bit is set, row readback is blocked and returns zeros together with a locked flag. Row writes are still accepted while the bit is set. The only way to clear the security bit is a whole-store erase. The erase runs for a fixed number of cycles with a busy flag and returns every row, the signature and the security bit to the unprogrammed state. The signature word can be read at any time, whatever the state of the lock.

The unprogrammed value of every cell is 1. Rows are `ROW_W` bits wide and are returned zero-extended to 64 bits.

Top module: `cfg_sec_store`

## Requirements
- R1: After reset, busy_o is low and cmd_ready_o is high, and no response is pending. Every row reads back as ROW_W ones (zero-extended) and the signature reads back as all ones, both with rsp_locked_o low.
- R2: Opcode 0 (write row) replaces the addressed row with cmd_data_i[ROW_W-1:0], without a prior erase. Later writes to the same row fully overwrite earlier ones. A later opcode 4 (read row) returns the row zero-extended while the store is unlocked.
- R3: Opcode 1 (write signature) stores all 64 bits of cmd_data_i. Opcode 5 (read signature) returns them.
- R4: After opcode 2 (set security) has been accepted, every row read returns all-zero data with rsp_locked_o high.
- R5: A signature read always returns the stored signature with rsp_locked_o low, whether or not security is set.
- R6: Row writes are accepted while security is set and update the stored row, but the row still reads back as zeros and locked.
- R7: Opcode 3 (erase) holds busy_o high and cmd_ready_o low for exactly ERASE_CYCLES cycles, starting on the cycle after acceptance. cmd_ready_o always equals the inverse of busy_o. Commands offered while busy are not accepted and have no effect.
- R8: When the erase finishes, every row and the signature hold all ones and the security bit is clear.
- R9: No command other than erase clears the security bit.
- R10: Opcodes 6 and 7 are accepted but change no stored state and produce no response.
- R11: rsp_valid_o is high for exactly the one cycle after each accepted read (opcode 4 or 5), and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be accepted this cycle |
| cmd_op_i | input | 3 | Opcode |
| cmd_addr_i | input | $clog2(ROWS) | Row address |
| cmd_data_i | input | 64 | Write data (row uses low ROW_W bits) |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | 64 | Read response data |
| rsp_locked_o | output | 1 | Row read blocked by security |
| busy_o | output | 1 | Erase in progress |

## Verification
The assertions check on every cycle that:
- ready is the inverse of busy;
- an accepted erase raises busy and busy lasts exactly ERASE_CYCLES cycles;
- a response appears only after an accepted read;
- a locked response carries zero data;
- a signature response is never locked.

Some behaviour depends on the stored contents, and only the bench's scenarios can show it. These scenarios cover:
- the overwrite of a row without erase;
- the survival of the lock across every non-erase command;
- the erased pattern after an erase;
- the absence of effect from commands offered while busy or with unused opcodes.

// File: rtl/cfg_sec_pkg.sv
package cfg_sec_pkg;
  localparam int unsigned DATA_W = 64;

  typedef enum logic [2:0] {
    OP_WR_ROW  = 3'd0,
    OP_WR_SIG  = 3'd1,
    OP_SET_SEC = 3'd2,
    OP_ERASE   = 3'd3,
    OP_RD_ROW  = 3'd4,
    OP_RD_SIG  = 3'd5
  } cfg_op_e;
endpackage

// File: rtl/cfg_fuse_store.sv
module cfg_fuse_store #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned ROW_W = 40,
  parameter int unsigned SIG_W = 64,
  localparam int unsigned AW   = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             row_we_i,
  input  logic [AW-1:0]    row_addr_i,
  input  logic [ROW_W-1:0] row_data_i,
  input  logic             sig_we_i,
  input  logic [SIG_W-1:0] sig_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [SIG_W-1:0] sig_o
);
  logic [ROW_W-1:0] row_q [ROWS];
  logic [SIG_W-1:0] sig_q;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic sel;
    assign sel = row_we_i && (row_addr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    row_q[g] <= '1;
      else if (clr_i) row_q[g] <= '1;
      else if (sel)   row_q[g] <= row_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sig_q <= '1;
    else if (clr_i)    sig_q <= '1;
    else if (sig_we_i) sig_q <= sig_data_i;
  end

  assign rd_row_o = row_q[rd_addr_i];
  assign sig_o    = sig_q;
endmodule

// File: rtl/cfg_lock.sv
module cfg_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sec_o
);
  logic sec_q;
  // erase wins; it never coincides with a set since busy blocks acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sec_q <= 1'b0;
    else if (clr_i) sec_q <= 1'b0;
    else if (set_i) sec_q <= 1'b1;
  end
  assign sec_o = sec_q;
endmodule

// File: rtl/cfg_erase_seq.sv
module cfg_erase_seq #(
  parameter int unsigned ERASE_CYCLES = 16,
  localparam int unsigned CW = $clog2(ERASE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(ERASE_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_sec_store.sv
module cfg_sec_store
  import cfg_sec_pkg::*;
#(
  parameter int unsigned ROWS         = 8,
  parameter int unsigned ROW_W        = 40,
  parameter int unsigned ERASE_CYCLES = 16,
  localparam int unsigned AW          = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [AW-1:0]     cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_locked_o,
  output logic              busy_o
);
  logic busy, clr, sec, acc;
  logic do_wr_row, do_wr_sig, do_set, do_erase, do_rd_row, do_rd_sig;
  logic [ROW_W-1:0]  rd_row;
  logic [DATA_W-1:0] sig, row_ext;

  assign cmd_ready_o = !busy;
  assign busy_o      = busy;
  assign acc         = cmd_valid_i && !busy;

  always_comb begin
    do_wr_row = 1'b0; do_wr_sig = 1'b0; do_set = 1'b0;
    do_erase  = 1'b0; do_rd_row = 1'b0; do_rd_sig = 1'b0;
    if (acc) begin
      case (cmd_op_i)
        OP_WR_ROW:  do_wr_row = 1'b1;
        OP_WR_SIG:  do_wr_sig = 1'b1;
        OP_SET_SEC: do_set    = 1'b1;
        OP_ERASE:   do_erase  = 1'b1;
        OP_RD_ROW:  do_rd_row = 1'b1;
        OP_RD_SIG:  do_rd_sig = 1'b1;
        default: ;
      endcase
    end
  end

  cfg_fuse_store #(.ROWS(ROWS), .ROW_W(ROW_W), .SIG_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .row_we_i   (do_wr_row),
    .row_addr_i (cmd_addr_i),
    .row_data_i (cmd_data_i[ROW_W-1:0]),
    .sig_we_i   (do_wr_sig),
    .sig_data_i (cmd_data_i),
    .rd_addr_i  (cmd_addr_i),
    .rd_row_o   (rd_row),
    .sig_o      (sig)
  );

  cfg_lock u_lock (
    .clk_i, .rst_ni,
    .set_i (do_set),
    .clr_i (clr),
    .sec_o (sec)
  );

  cfg_erase_seq #(.ERASE_CYCLES(ERASE_CYCLES)) u_erase (
    .clk_i, .rst_ni,
    .start_i (do_erase),
    .busy_o  (busy),
    .done_o  (clr)
  );

  always_comb begin
    row_ext = '0;
    row_ext[ROW_W-1:0] = rd_row;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_data_o   <= '0;
      rsp_locked_o <= 1'b0;
    end else begin
      rsp_valid_o <= do_rd_row || do_rd_sig;
      if (do_rd_sig) begin
        rsp_data_o   <= sig;
        rsp_locked_o <= 1'b0;
      end else if (do_rd_row) begin
        rsp_data_o   <= sec ? '0 : row_ext;
        rsp_locked_o <= sec;
      end
    end
  end
endmodule

// File: rtl/cfg_sec_store_chk.sv
module cfg_sec_store_chk
  import cfg_sec_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 16,
  parameter int unsigned AW           = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [2:0]        cmd_op_i,
  input logic [AW-1:0]     cmd_addr_i,
  input logic [DATA_W-1:0] cmd_data_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              rsp_locked_o,
  input logic              busy_o
);
  localparam int unsigned CW = $clog2(ERASE_CYCLES + 2);
  logic          acc;
  logic          rd_q, sig_q;
  logic [CW-1:0] run_q;

  assign acc = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      sig_q <= 1'b0;
      run_q <= '0;
    end else begin
      rd_q  <= acc && (cmd_op_i == OP_RD_ROW || cmd_op_i == OP_RD_SIG);
      sig_q <= acc && (cmd_op_i == OP_RD_SIG);
      run_q <= busy_o ? run_q + 1'b1 : '0;
    end
  end

  p_ready_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o == !busy_o);
  p_erase_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == OP_ERASE) |=> busy_o);
  p_busy_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < CW'(ERASE_CYCLES)));
  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == CW'(ERASE_CYCLES)));
  p_rsp_after_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == rd_q);
  p_locked_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_locked_o) |-> (rsp_data_o == '0));
  p_sig_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && sig_q) |-> !rsp_locked_o);
endmodule

bind cfg_sec_store cfg_sec_store_chk #(.ERASE_CYCLES(ERASE_CYCLES), .AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_op_i     (cmd_op_i),
  .cmd_addr_i   (cmd_addr_i),
  .cmd_data_i   (cmd_data_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_data_o   (rsp_data_o),
  .rsp_locked_o (rsp_locked_o),
  .busy_o       (busy_o)
);

// File: tb/cfg_sec_store_bench.sv
module cfg_sec_store_bench;
  localparam int PERIOD = 10;
  localparam int ROWS   = 8;
  localparam int ROW_W  = 40;
  localparam int ERASE  = 16;
  localparam int AW     = 3;
  localparam logic [63:0] ROW_MASK = (64'd1 << ROW_W) - 64'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic rsp_valid, rsp_locked, busy;
  logic [63:0] rsp_data;

  int total = 0, bad = 0;
  logic [63:0] exp_row [ROWS];
  logic [63:0] exp_sig;
  logic exp_sec;

  always #(PERIOD/2) clk = ~clk;

  cfg_sec_store #(.ROWS(ROWS), .ROW_W(ROW_W), .ERASE_CYCLES(ERASE)) u_cfg_sec_store (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_locked_o(rsp_locked),
    .busy_o(busy)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 3)) ^ (64'(i) << 11);
  endfunction

  // drive at negedge, accepted at next posedge, returns at the following negedge
  task automatic issue(input logic [2:0] op, input int addr, input logic [63:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(input logic [2:0] op, input int addr, input string req);
    logic [63:0] e;
    logic        l;
    issue(op, addr, '0);
    if (op == 3'd5) begin e = exp_sig; l = 1'b0; end
    else if (exp_sec) begin e = '0; l = 1'b1; end
    else begin e = exp_row[addr] & ROW_MASK; l = 1'b0; end
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({req, " data"}, rsp_data, e);
    check({req, " locked"}, 64'(rsp_locked), 64'(l));
    @(negedge clk);
    check("R11 single-cycle response", 64'(rsp_valid), 64'd0);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < ROWS; i++) read_chk(3'd4, i, req);
    read_chk(3'd5, 0, req);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROWS; i++) exp_row[i] = '1;
    exp_sig = '1; exp_sec = 1'b0;
    #(PERIOD * 3);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 ready", 64'(cmd_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    read_all("R1 reset contents");

    // R2: write every row, overwrite, read back
    for (int i = 0; i < ROWS; i++) begin issue(3'd0, i, pat(i)); exp_row[i] = pat(i); end
    for (int i = 0; i < ROWS; i += 2) begin issue(3'd0, i, ~pat(i + 20)); exp_row[i] = ~pat(i + 20); end
    read_all("R2 row write/overwrite");

    // R3
    issue(3'd1, 0, 64'hA5C3_0F1E_5566_7788); exp_sig = 64'hA5C3_0F1E_5566_7788;
    read_chk(3'd5, 0, "R3 signature");
    check("R10 no rsp after write", 64'(rsp_valid), 64'd0);

    // R10: unused opcodes
    issue(3'd6, 2, 64'h0); issue(3'd7, 5, 64'h1234);
    check("R10 no response", 64'(rsp_valid), 64'd0);
    read_all("R10 unused opcodes no effect");

    // R4/R5
    issue(3'd2, 0, '0); exp_sec = 1'b1;
    read_all("R4 locked rows, R5 signature open");

    // R6/R9: writes while locked; nothing but erase clears the lock
    issue(3'd0, 3, 64'h0); exp_row[3] = '0;
    issue(3'd1, 0, 64'h0BAD_F00D_1234_5678); exp_sig = 64'h0BAD_F00D_1234_5678;
    issue(3'd2, 0, '0); issue(3'd6, 0, '0); issue(3'd7, 0, '1);
    read_all("R6 R9 lock persists");

    // R7: erase timing, commands during busy ignored
    begin
      int n = 0;
      issue(3'd3, 0, '0);
      check("R7 busy after erase", 64'(busy), 64'd1);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 64'h1111;
      while (busy && n < 100) begin
        check("R7 ready low while busy", 64'(cmd_ready), 64'd0);
        n++;
        if (n == 3) cmd_valid = 1'b0;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      check("R7 busy length", 64'(n), 64'(ERASE));
      check("R7 ready after erase", 64'(cmd_ready), 64'd1);
    end
    for (int i = 0; i < ROWS; i++) exp_row[i] = '1;
    exp_sig = '1; exp_sec = 1'b0;
    read_all("R8 erased state");

    // R2 after erase: store programmable and readable again
    for (int i = 0; i < ROWS; i++) begin issue(3'd0, i, pat(i + 50)); exp_row[i] = pat(i + 50); end
    read_all("R2 reprogram after erase");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule